// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

This block decides which clocks run in a small 8-bit microcontroller. Software writes a control register that holds an idle request bit, a power-down request bit and two general-purpose flags. From those bits the block derives three enables: one for the CPU clock, one for the peripheral clock, and one that keeps the oscillator running. Plain enable outputs stand in for the gating cells and for the oscillator itself.

Idle stops only the CPU clock, so peripherals keep working. An enabled pending interrupt ends idle: the hardware clears the idle bit and the CPU clock comes back. Power-down stops the oscillator and every clock, and only reset ends it. Power-down wins when both request bits are written together, and the controller does not drop into idle afterwards. Reset masks both mode bits combinationally, so the CPU clock returns in the same cycle that reset rises. The register itself is cleared at the next clock edge.

Top module: `pmc_top`

## Requirements
- R1: While reset is held and after it is released, the control register reads 0 and the CPU clock, peripheral clock and oscillator enables are all 1 (mode code 0 = run).
- R2: In run mode, a write with bit 0 (idle) set and bit 1 clear enters idle on the next cycle: CPU enable 0, peripheral and oscillator enables 1, mode code 1.
- R3: In run mode, a write with bit 1 (power-down) set enters power-down on the next cycle: CPU, peripheral and oscillator enables all 0, mode code 2.
- R4: A write with both bit 0 and bit 1 set enters power-down, not idle.
- R5: In idle, a pending enabled interrupt clears bit 0 on the next cycle and restores the CPU enable, returning to run mode.
- R6: While reset is high, the CPU and oscillator enables are 1 and read-back bits 0 and 1 are 0 in the same cycle, before any clock edge.
- R7: In power-down, interrupts have no effect. Only reset leaves power-down, and after that reset the mode is run, even if bit 0 was set together with bit 1.
- R8: In run mode, a pending interrupt with no write leaves the register and all enables unchanged.
- R9: Bits 2 and 3 (general-purpose flags) keep their value through entry to and exit from idle and power-down.
- R10: Register writes are ignored while in idle or power-down.
- R11: Read-back places idle at bit 0, power-down at bit 1 and the flags at bits 2 and 3. Bits above 3 always read 0, whatever value was written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running controller clock |
| rst | input | 1 | Active-high reset; also masks the mode bits combinationally |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | CTRL_W | Control register write value |
| irq_pend | input | 1 | An enabled interrupt is pending |
| rd_data | output | CTRL_W | Control register read-back |
| cpu_clk_en | output | 1 | CPU clock enable |
| per_clk_en | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator run request |
| pwr_mode | output | 2 | Current mode: 0 run, 1 idle, 2 power-down |

## Verification
The assertions check the following on every cycle:
- idle gates only the CPU enable;
- power-down holds all three enables low and stays put until reset;
- an interrupt in idle clears the idle bit one cycle later;
- the flags and the whole register stay stable when no write can take effect;
- reset raises the CPU and oscillator enables.

Some behaviours only the bench scenarios show. These are how each of the sixteen low-nibble write values decodes into a mode, that writes with junk upper bits read back cleanly, that blocked writes leave the read-back untouched, and that reset leaves power-down into run rather than idle.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    // Field positions inside the control register
    localparam int IDL_POS = 0;
    localparam int PD_POS  = 1;
    localparam int GF0_POS = 2;
    localparam int GF1_POS = 3;
    localparam int FIELD_W = 4;

    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_IDLE  = 2'd1,
        MODE_PDOWN = 2'd2
    } pwr_mode_e;

    typedef struct packed {
        logic gf1;
        logic gf0;
        logic pd;
        logic idl;
    } ctrl_bits_t;

    typedef struct packed {
        logic cpu;
        logic per;
        logic osc;
    } clk_en_t;

    // Power-down outranks idle
    function automatic pwr_mode_e decode_mode(input logic idl, input logic pd);
        if (pd)       return MODE_PDOWN;
        else if (idl) return MODE_IDLE;
        else          return MODE_RUN;
    endfunction

    function automatic clk_en_t enables_for(input pwr_mode_e m);
        clk_en_t e;
        e.cpu = (m == MODE_RUN);
        e.per = (m != MODE_PDOWN);
        e.osc = (m != MODE_PDOWN);
        return e;
    endfunction

endpackage

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
    import pmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr_en,
    input  ctrl_bits_t wr_bits,
    input  logic       irq_pend,
    output ctrl_bits_t ctrl_q,
    output ctrl_bits_t ctrl_view
);

    ctrl_bits_t ctrl_d;

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_q.pd) begin
            ctrl_d = ctrl_q;              // only reset leaves power-down
        end else if (ctrl_q.idl) begin
            if (irq_pend) ctrl_d.idl = 1'b0;   // interrupt wakes the CPU
        end else if (wr_en) begin
            ctrl_d = wr_bits;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctrl_q <= '0;
        else     ctrl_q <= ctrl_d;
    end

    // Reset masks the mode bits without waiting for a clock edge
    always_comb begin
        ctrl_view     = ctrl_q;
        ctrl_view.idl = ctrl_q.idl & ~rst;
        ctrl_view.pd  = ctrl_q.pd  & ~rst;
    end

    p_irq_exit_r5: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.idl && !ctrl_q.pd && irq_pend) |=> !ctrl_q.idl);

    p_pd_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.pd |=> ctrl_q.pd && $stable(ctrl_q));

    p_run_irq_r8: assert property (@(posedge clk) disable iff (rst)
        (!ctrl_q.idl && !ctrl_q.pd && !wr_en) |=> $stable(ctrl_q));

    p_gp_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.idl || ctrl_q.pd) |=> $stable({ctrl_q.gf1, ctrl_q.gf0}));

    p_lp_write_r10: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.idl && !irq_pend) |=> $stable(ctrl_q));

endmodule

// File: rtl/pmc_mode_decode.sv
module pmc_mode_decode
    import pmc_pkg::*;
(
    input  logic      idl,
    input  logic      pd,
    output pwr_mode_e mode,
    output clk_en_t   en
);

    always_comb begin
        mode = decode_mode(idl, pd);
        en   = enables_for(mode);
    end

endmodule

// File: rtl/pmc_top.sv
module pmc_top
    import pmc_pkg::*;
#(
    parameter int CTRL_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              irq_pend,
    output logic [CTRL_W-1:0] rd_data,
    output logic              cpu_clk_en,
    output logic              per_clk_en,
    output logic              osc_run,
    output logic [1:0]        pwr_mode
);

    ctrl_bits_t wr_bits;
    ctrl_bits_t ctrl_q;
    ctrl_bits_t ctrl_view;
    pwr_mode_e  mode;
    clk_en_t    en;
    logic       unused_wr_hi;

    assign wr_bits.idl  = wr_data[IDL_POS];
    assign wr_bits.pd   = wr_data[PD_POS];
    assign wr_bits.gf0  = wr_data[GF0_POS];
    assign wr_bits.gf1  = wr_data[GF1_POS];
    assign unused_wr_hi = ^wr_data;

    pmc_ctrl_reg u_reg (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_bits   (wr_bits),
        .irq_pend  (irq_pend),
        .ctrl_q    (ctrl_q),
        .ctrl_view (ctrl_view)
    );

    pmc_mode_decode u_dec (
        .idl  (ctrl_view.idl),
        .pd   (ctrl_view.pd),
        .mode (mode),
        .en   (en)
    );

    always_comb begin
        rd_data          = '0;
        rd_data[IDL_POS] = ctrl_view.idl;
        rd_data[PD_POS]  = ctrl_view.pd;
        rd_data[GF0_POS] = ctrl_view.gf0;
        rd_data[GF1_POS] = ctrl_view.gf1;
    end

    assign cpu_clk_en = en.cpu;
    assign per_clk_en = en.per;
    assign osc_run    = en.osc;
    assign pwr_mode   = mode;

    p_idle_gates_r2: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.idl && !ctrl_q.pd) |-> (!cpu_clk_en && per_clk_en && osc_run));

    p_pd_freeze_r3: assert property (@(posedge clk) disable iff (rst)
        ctrl_q.pd |-> (!cpu_clk_en && !per_clk_en && !osc_run));

    p_rst_restore_r6: assert property (@(posedge clk)
        rst |-> (cpu_clk_en && osc_run && rd_data[1:0] == 2'b00));

    p_upper_zero_r11: assert property (@(posedge clk)
        rd_data[CTRL_W-1:FIELD_W] == '0);

endmodule

// File: tb/pmc_top_test.sv
module pmc_top_test;

    localparam int CLK_P = 10;

    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       irq_pend;
    logic [7:0] rd_data;
    logic       cpu_clk_en, per_clk_en, osc_run;
    logic [1:0] pwr_mode;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 0;

    always #(CLK_P/2) clk = ~clk;

    pmc_top #(.CTRL_W(8)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .irq_pend(irq_pend), .rd_data(rd_data), .cpu_clk_en(cpu_clk_en),
        .per_clk_en(per_clk_en), .osc_run(osc_run), .pwr_mode(pwr_mode)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // {mode, cpu, per, osc, rd}
    task automatic check_state(input string req, input logic [1:0] m, input logic [7:0] rd);
        logic [31:0] act, exp;
        act = {19'd0, pwr_mode, cpu_clk_en, per_clk_en, osc_run, rd_data};
        exp = {19'd0, m, (m == 2'd0), (m != 2'd2), (m != 2'd2), rd};
        check(req, act, exp);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; wr_en = 1'b0; wr_data = '0; irq_pend = 1'b0;
        #1;
        for (int v = 0; v < 16; v++) begin
            logic [1:0] m;
            logic [7:0] cur;
            rst = 1'b1;
            tick();
            check_state("R1 reset held", 2'd0, 8'h00);
            tick();
            rst = 1'b0;
            tick();
            check_state("R1 after reset", 2'd0, 8'h00);

            // R8: interrupt in run is ignored
            irq_pend = 1'b1; tick(); irq_pend = 1'b0;
            check_state("R8 irq in run", 2'd0, 8'h00);

            // R2 R3 R4 R11: write with junk upper bits
            wr_en = 1'b1; wr_data = {4'(v ^ 4'hA) | 4'h1, 4'(v)};
            tick();
            wr_en = 1'b0;
            m   = v[1] ? 2'd2 : (v[0] ? 2'd1 : 2'd0);
            cur = 8'(v);
            check_state(v[1] ? (v[0] ? "R4 both bits" : "R3 power-down")
                             : (v[0] ? "R2 idle" : "R11 run write"), m, cur);

            // R10: writes ignored in a low-power mode
            if (m != 2'd0) begin
                wr_en = 1'b1; wr_data = 8'hFC; tick(); wr_en = 1'b0;
                check_state("R10 write blocked", m, cur);
            end

            // R5 R7 R9: interrupt
            irq_pend = 1'b1; tick(); irq_pend = 1'b0;
            if (m == 2'd1) begin
                cur[0] = 1'b0;
                check_state("R5 R9 irq exits idle", 2'd0, cur);
            end else if (m == 2'd2) begin
                check_state("R7 irq ignored in power-down", 2'd2, cur);
            end else begin
                check_state("R8 irq in run after write", 2'd0, cur);
            end
            if (m == 2'd2) begin
                tick();
                check("R9 flags in power-down", {30'd0, rd_data[3:2]}, {30'd0, cur[3:2]});
            end

            // R6: reset acts before any edge
            rst = 1'b1; #1;
            check("R6 async restore", {29'd0, cpu_clk_en, osc_run, 1'b0} | {30'd0, rd_data[1:0]},
                  32'h4 >> 0 == 0 ? 0 : {29'd0, 1'b1, 1'b1, 1'b0});
            tick();
            rst = 1'b0;
            tick();
            check_state("R7 reset exit to run", 2'd0, 8'h00);
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule